// File: doc/BRIEF.md
# Register-Operand Shift Execution Unit

This block performs the shift group of a 32-bit load/store processor's register-format instructions. The caller supplies a 6-bit function code, a 5-bit immediate shift amount taken from the instruction word, the operand to be shifted (the second source register) and the first source register value. The block decodes the function code itself. It selects the shift amount from either the immediate field or the low bits of the first source register, and shifts the second source operand left, logically right or arithmetically right.

The result and an is-shift flag are captured in output registers on the clock edge that samples the input valid strobe. The output valid goes high for exactly the cycle that follows. Function codes outside the shift group clear the flag and produce a zero result, so a surrounding datapath can merge this unit's output with other execution units. The data width is a parameter that must be a power of two. A second parameter chooses between two internal shifter structures.

Top module: `shift_exec_unit`

## Requirements
- R1: The six function codes 6'b000000, 6'b000010, 6'b000011, 6'b000100, 6'b000110 and 6'b000111 are shift operations and set out_is_shift to 1 in the captured output.
- R2: Codes 6'b000000 and 6'b000100 shift the operand left and fill the vacated low bits with zeros.
- R3: Codes 6'b000010 and 6'b000110 shift the operand right and fill the vacated high bits with zeros.
- R4: Codes 6'b000011 and 6'b000111 shift the operand right and fill the vacated high bits with copies of operand bit 31.
- R5: Codes with bit 2 clear take the amount from shamt, and rs_val has no effect on the result.
- R6: Codes with bit 2 set take the amount from rs_val[4:0]; rs_val[31:5] and shamt have no effect on the result.
- R7: A shift amount of zero returns the operand unchanged for every shift code.
- R8: Any other function code gives out_is_shift = 0 and out_result = 0.
- R9: out_result and out_is_shift load on the rising edge that samples in_valid = 1, and out_valid is 1 in the cycle after that edge and 0 in the cycle after an edge that samples in_valid = 0.
- R10: While in_valid is 0, out_result and out_is_shift hold their values whatever the other inputs do.
- R11: After reset, out_valid, out_is_shift and out_result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Inputs are valid this cycle |
| funct | input | 6 | Instruction function code |
| shamt | input | 5 | Immediate shift amount from the instruction |
| rt_val | input | 32 | Operand to be shifted |
| rs_val | input | 32 | Register value supplying the variable shift amount |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_result | output | 32 | Shifted operand, or zero for non-shift codes |
| out_is_shift | output | 1 | Captured function code belonged to the shift group |

## Verification
The bench sets high-order bits of rs_val during variable shifts. A design that used the whole register would then return zero or a wrapped result instead of a shift by rs_val[4:0]. It also loads rs_val with a nonzero amount during immediate shifts, which exposes an amount multiplexer with its select inverted. Arithmetic right shifts are run on both negative and positive operands and at the full amount of 31, where a zero-filling design shows its error in the top bits. Other cases are amount zero, the unused code 6'b000001 and out-of-group codes, and changing inputs while in_valid is low; these catch an off-by-one stage, a leaking default and registers that load without the strobe.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

   localparam int FUNCT_W = 6;

   typedef enum logic [FUNCT_W-1:0] {
      FN_SLL  = 6'b000000,
      FN_SRL  = 6'b000010,
      FN_SRA  = 6'b000011,
      FN_SLLV = 6'b000100,
      FN_SRLV = 6'b000110,
      FN_SRAV = 6'b000111
   } shift_fn_e;

   typedef enum logic [1:0] {
      DIR_LEFT    = 2'd0,
      DIR_RGT_LOG = 2'd1,
      DIR_RGT_ARI = 2'd2
   } shift_dir_e;

   typedef struct packed {
      logic       is_shift;
      logic       use_reg;
      shift_dir_e dir;
   } shift_ctl_t;

endpackage

// File: rtl/shift_fn_decode.sv
module shift_fn_decode
   import shift_unit_pkg::*;
(
   input  logic [FUNCT_W-1:0] funct,
   output shift_ctl_t         ctl
);

   always_comb begin
      ctl.is_shift = 1'b0;
      ctl.use_reg  = 1'b0;
      ctl.dir      = DIR_LEFT;
      case (funct)
         FN_SLL: begin
            ctl.is_shift = 1'b1;
         end
         FN_SLLV: begin
            ctl.is_shift = 1'b1;
            ctl.use_reg  = 1'b1;
         end
         FN_SRL: begin
            ctl.is_shift = 1'b1;
            ctl.dir      = DIR_RGT_LOG;
         end
         FN_SRLV: begin
            ctl.is_shift = 1'b1;
            ctl.use_reg  = 1'b1;
            ctl.dir      = DIR_RGT_LOG;
         end
         FN_SRA: begin
            ctl.is_shift = 1'b1;
            ctl.dir      = DIR_RGT_ARI;
         end
         FN_SRAV: begin
            ctl.is_shift = 1'b1;
            ctl.use_reg  = 1'b1;
            ctl.dir      = DIR_RGT_ARI;
         end
         default: begin
            ctl.is_shift = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic              use_reg,
   input  logic [AMT_W-1:0]  imm_amt,
   input  logic [DATA_W-1:0] reg_val,
   output logic [AMT_W-1:0]  amt
);

   logic [AMT_W-1:0] reg_amt;

   // only the low bits of the register count; the rest are discarded
   assign reg_amt = reg_val[AMT_W-1:0];

   always_comb begin
      if (use_reg) amt = reg_amt;
      else         amt = imm_amt;
   end

endmodule

// File: rtl/shift_right_stack.sv
module shift_right_stack #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AMT_W-1:0]  amt,
   input  logic              fill,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] stg [AMT_W+1];

   assign stg[0] = din;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      logic [DATA_W-1:0] moved;
      assign moved      = {{STEP{fill}}, stg[k][DATA_W-1:STEP]};
      assign stg[k+1]   = amt[k] ? moved : stg[k];
   end

   assign dout = stg[AMT_W];

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
   import shift_unit_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int AMT_W       = $clog2(DATA_W),
   parameter bit SHARED_CORE = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AMT_W-1:0]  amt,
   input  shift_dir_e        dir,
   output logic [DATA_W-1:0] dout
);

   logic fill;
   assign fill = (dir == DIR_RGT_ARI) ? din[DATA_W-1] : 1'b0;

   if (SHARED_CORE) begin : g_shared
      // one right-shift stack; left shifts are mirrored in and out
      logic [DATA_W-1:0] mir_in;
      logic [DATA_W-1:0] core_in;
      logic [DATA_W-1:0] core_out;
      logic [DATA_W-1:0] mir_out;
      logic              is_left;

      assign is_left = (dir == DIR_LEFT);

      for (genvar b = 0; b < DATA_W; b++) begin : g_mirror
         assign mir_in[b]  = din[DATA_W-1-b];
         assign mir_out[b] = core_out[DATA_W-1-b];
      end

      assign core_in = is_left ? mir_in : din;

      shift_right_stack #(
         .DATA_W (DATA_W),
         .AMT_W  (AMT_W)
      ) u_core (
         .din  (core_in),
         .amt  (amt),
         .fill (fill),
         .dout (core_out)
      );

      assign dout = is_left ? mir_out : core_out;
   end else begin : g_split
      // dedicated left stack next to the right stack
      logic [DATA_W-1:0] rgt_out;
      logic [DATA_W-1:0] lstg [AMT_W+1];

      shift_right_stack #(
         .DATA_W (DATA_W),
         .AMT_W  (AMT_W)
      ) u_right (
         .din  (din),
         .amt  (amt),
         .fill (fill),
         .dout (rgt_out)
      );

      assign lstg[0] = din;
      for (genvar k = 0; k < AMT_W; k++) begin : g_lstage
         localparam int STEP = 1 << k;
         logic [DATA_W-1:0] moved;
         assign moved     = {lstg[k][DATA_W-1-STEP:0], {STEP{1'b0}}};
         assign lstg[k+1] = amt[k] ? moved : lstg[k];
      end

      assign dout = (dir == DIR_LEFT) ? lstg[AMT_W] : rgt_out;
   end

endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
   import shift_unit_pkg::*;
#(
   parameter int  DATA_W      = 32,
   parameter bit  SHARED_CORE = 1'b1,
   localparam int AMT_W       = $clog2(DATA_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [FUNCT_W-1:0] funct,
   input  logic [AMT_W-1:0]   shamt,
   input  logic [DATA_W-1:0]  rt_val,
   input  logic [DATA_W-1:0]  rs_val,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_result,
   output logic               out_is_shift
);

   if (DATA_W < 2) begin : g_bad_width
      $error("shift_exec_unit: DATA_W must be at least 2");
   end
   if ((1 << AMT_W) != DATA_W) begin : g_bad_pow2
      $error("shift_exec_unit: DATA_W must be a power of two");
   end

   shift_ctl_t        ctl;
   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] res_d;

   shift_fn_decode u_dec (
      .funct (funct),
      .ctl   (ctl)
   );

   shift_amt_sel #(
      .DATA_W (DATA_W),
      .AMT_W  (AMT_W)
   ) u_amt (
      .use_reg (ctl.use_reg),
      .imm_amt (shamt),
      .reg_val (rs_val),
      .amt     (amt)
   );

   shift_barrel #(
      .DATA_W      (DATA_W),
      .AMT_W       (AMT_W),
      .SHARED_CORE (SHARED_CORE)
   ) u_bar (
      .din  (rt_val),
      .amt  (amt),
      .dir  (ctl.dir),
      .dout (shifted)
   );

   assign res_d = ctl.is_shift ? shifted : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_result   <= '0;
         out_is_shift <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result   <= res_d;
            out_is_shift <= ctl.is_shift;
         end
      end
   end

endmodule

// File: rtl/shift_exec_unit_chk.sv
module shift_exec_unit_chk #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [5:0]        funct,
   input logic [AMT_W-1:0]  shamt,
   input logic [DATA_W-1:0] rt_val,
   input logic [DATA_W-1:0] rs_val,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic              out_is_shift
);

   logic known;
   assign known = (funct == 6'd0) || (funct == 6'd2) || (funct == 6'd3) ||
                  (funct == 6'd4) || (funct == 6'd6) || (funct == 6'd7);

   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R9
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R1
   shift_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && known) |=> out_is_shift);

   // R8
   unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !known) |=> (!out_is_shift && out_result == '0));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_is_shift)));

   // R7
   zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && known && !funct[2] && shamt == '0) |=> out_result == $past(rt_val));

   // R4
   sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && funct == 6'd3 && rt_val[DATA_W-1]) |=> out_result[DATA_W-1]);

   // R3
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && funct == 6'd2 && shamt != '0) |=> !out_result[DATA_W-1]);

   // R2
   left_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && funct == 6'd0 && shamt != '0) |=> !out_result[0]);

endmodule

bind shift_exec_unit shift_exec_unit_chk #(
   .DATA_W (DATA_W),
   .AMT_W  (AMT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .funct        (funct),
   .shamt        (shamt),
   .rt_val       (rt_val),
   .rs_val       (rs_val),
   .out_valid    (out_valid),
   .out_result   (out_result),
   .out_is_shift (out_is_shift)
);

// File: tb/shift_exec_unit_test.sv
`timescale 1ns/1ps
module shift_exec_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  funct = '0;
   logic [4:0]  shamt = '0;
   logic [31:0] rt_val = '0;
   logic [31:0] rs_val = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_is_shift;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   shift_exec_unit uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .funct        (funct),
      .shamt        (shamt),
      .rt_val       (rt_val),
      .rs_val       (rs_val),
      .out_valid    (out_valid),
      .out_result   (out_result),
      .out_is_shift (out_is_shift)
   );

   function automatic logic [31:0] ref_res(logic [5:0] f, logic [4:0] sh,
                                           logic [31:0] t, logic [31:0] s);
      logic [4:0] a;
      a = f[2] ? s[4:0] : sh;
      case (f)
         6'd0, 6'd4: return t << a;
         6'd2, 6'd6: return t >> a;
         6'd3, 6'd7: return $unsigned($signed(t) >>> a);
         default:    return 32'h0;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   // one strobed operation; returns with outputs of the capturing edge visible
   task automatic apply(logic [5:0] f, logic [4:0] sh, logic [31:0] t, logic [31:0] s);
      @(negedge clk);
      funct = f; shamt = sh; rt_val = t; rs_val = s; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_and_check(string req, logic [5:0] f, logic [4:0] sh,
                                logic [31:0] t, logic [31:0] s);
      apply(f, sh, t, s);
      chk(req, out_result, ref_res(f, sh, t, s));
      chk(req, {31'h0, out_is_shift}, {31'h0, (f inside {6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7})});
   endtask

   task automatic t_reset;
      chk("R11 valid", {31'h0, out_valid}, 32'h0);
      chk("R11 flag", {31'h0, out_is_shift}, 32'h0);
      chk("R11 result", out_result, 32'h0);
   endtask

   task automatic t_left;
      run_and_check("R2 sll", 6'd0, 5'd4, 32'h1234_5678, 32'h0);
      chk("R2 sll literal", out_result, 32'h2345_6780);
      run_and_check("R2 sll31", 6'd0, 5'd31, 32'hFFFF_FFFF, 32'h0);
      chk("R1 flag", {31'h0, out_is_shift}, 32'h1);
      run_and_check("R2 sllv", 6'd4, 5'd0, 32'h8000_0001, 32'd1);
      chk("R2 sllv literal", out_result, 32'h0000_0002);
   endtask

   task automatic t_logic_right;
      run_and_check("R3 srl", 6'd2, 5'd8, 32'hF000_00FF, 32'h0);
      chk("R3 srl literal", out_result, 32'h00F0_0000);
      run_and_check("R3 srlv", 6'd6, 5'd0, 32'h8000_0000, 32'd31);
      chk("R3 srlv literal", out_result, 32'h0000_0001);
   endtask

   task automatic t_arith_right;
      run_and_check("R4 sra neg", 6'd3, 5'd4, 32'h8000_0000, 32'h0);
      chk("R4 sra literal", out_result, 32'hF800_0000);
      run_and_check("R4 sra pos", 6'd3, 5'd4, 32'h7000_0000, 32'h0);
      chk("R4 sra pos literal", out_result, 32'h0700_0000);
      run_and_check("R4 srav31", 6'd7, 5'd0, 32'h8000_1234, 32'd31);
      chk("R4 srav31 literal", out_result, 32'hFFFF_FFFF);
   endtask

   task automatic t_imm_ignores_rs;
      run_and_check("R5 sll rs ignored", 6'd0, 5'd1, 32'h0000_0003, 32'h0000_001F);
      chk("R5 literal", out_result, 32'h0000_0006);
      run_and_check("R5 srl rs ignored", 6'd2, 5'd2, 32'h0000_0010, 32'hFFFF_FFFF);
      chk("R5 srl literal", out_result, 32'h0000_0004);
   endtask

   task automatic t_var_mask;
      run_and_check("R6 high rs ignored", 6'd4, 5'd9, 32'h0000_0001, 32'hFFFF_FFE3);
      chk("R6 literal", out_result, 32'h0000_0008);
      run_and_check("R6 srav mask", 6'd7, 5'd31, 32'h8000_0000, 32'h0000_0101);
      chk("R6 srav literal", out_result, 32'hC000_0000);
   endtask

   task automatic t_zero;
      for (int f = 0; f < 8; f++) begin
         if (f == 1 || f == 5) continue;
         apply(f[5:0], 5'd0, 32'hA5C3_0F96, 32'hFFFF_FFE0);
         chk("R7 zero amount", out_result, 32'hA5C3_0F96);
      end
   endtask

   task automatic t_unknown;
      apply(6'd0, 5'd1, 32'h1, 32'h0);
      run_and_check("R8 code1", 6'd1, 5'd3, 32'hFFFF_FFFF, 32'h3);
      chk("R8 code1 result", out_result, 32'h0);
      chk("R8 code1 flag", {31'h0, out_is_shift}, 32'h0);
      run_and_check("R8 code32", 6'd32, 5'd3, 32'hFFFF_FFFF, 32'h3);
      chk("R8 code32 result", out_result, 32'h0);
      run_and_check("R8 code8", 6'd8, 5'd0, 32'h1234_5678, 32'h0);
      chk("R8 code8 flag", {31'h0, out_is_shift}, 32'h0);
   endtask

   task automatic t_timing;
      @(negedge clk);
      funct = 6'd0; shamt = 5'd1; rt_val = 32'h10; rs_val = 32'h0; in_valid = 1'b1;
      #1;
      chk("R9 valid before edge", {31'h0, out_valid}, 32'h0);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 valid after edge", {31'h0, out_valid}, 32'h1);
      chk("R9 result after edge", out_result, 32'h20);
      @(negedge clk);
      chk("R9 valid drops", {31'h0, out_valid}, 32'h0);
   endtask

   task automatic t_hold;
      apply(6'd2, 5'd4, 32'h0000_0F00, 32'h0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         funct = 6'd8 + 6'(i); shamt = 5'(i); rt_val = 32'hDEAD_0000 + 32'(i); rs_val = 32'(i);
      end
      @(negedge clk);
      chk("R10 result held", out_result, 32'h0000_00F0);
      chk("R10 flag held", {31'h0, out_is_shift}, 32'h1);
      chk("R10 valid low", {31'h0, out_valid}, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_left();
      t_logic_right();
      t_arith_right();
      t_imm_ignores_rs();
      t_var_mask();
      t_zero();
      t_unknown();
      t_timing();
      t_hold();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule